// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block carries out a combined count-and-branch step for a small processor core. A single control byte picks one of eight registers and one of three actions: count down by one, count up by one, or leave the value alone and only test it. The same byte picks whether the branch fires on a zero result or on a nonzero result, and it supplies the sign bit of a 9-bit branch displacement. The low eight bits of that displacement arrive on a separate offset input.

The core presents the control byte, the offset byte and the current program counter together with a one-cycle `execValid` strobe. The block reads the selected register through a read port whose select follows the control byte combinationally. On the next clock edge it registers four things: the updated value for the register write port, a taken flag, the next program counter, and a flag for an illegal control byte. Registers 0 to 2 are 8 bits wide. For those, the count and the zero test use only the low byte, and the upper byte written back is zero.

Top module: `loopbr_unit`

## Requirements
- R1: While `rstN` is low and after it rises, `brDone`, `regWrEn`, `brTaken`, `illegalOp`, `regWrData` and `nextPc` are all zero until the first operation completes.
- R2: `brDone` is high for exactly the one cycle that follows each clock edge at which `execValid` was high, and low otherwise.
- R3: Control byte bits 7:6 = 00 writes back the register value minus one, modulo the register width.
- R4: Control byte bits 7:6 = 01 writes back the register value unchanged.
- R5: Control byte bits 7:6 = 10 writes back the register value plus one, modulo the register width.
- R6: Control byte bits 7:6 = 11 is illegal: `illegalOp` is high with `brDone`, no register is written, no branch is taken, and `nextPc` equals the presented PC.
- R7: For a legal operation, bit 5 = 1 takes the branch when the written-back value is nonzero, and bit 5 = 0 takes it when that value is zero.
- R8: When the branch is taken, `nextPc` is the PC plus the 16-bit sign extension of {bit 4, offset byte}, modulo 2^16. When it is not taken, `nextPc` is the presented PC.
- R9: For registers 0, 1 and 2 (8-bit), the count and the zero test use only bits 7:0 of the read value, and `regWrData[15:8]` is zero.
- R10: `regRdSel` equals control byte bits 2:0 at all times. Every legal operation asserts `regWrEn` with `brDone` and with `regWrSel` equal to those bits, whether or not the branch is taken.
- R11: For registers 3 to 7 (16-bit), the count wraps over the full 16 bits: 0xFFFF plus one gives 0x0000, and 0x7FFF plus one gives 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| execValid | input | 1 | Start one operation this cycle |
| postByte | input | 8 | Control byte: action, branch sense, offset sign, register select |
| offsetByte | input | 8 | Low eight bits of the branch displacement |
| pcIn | input | 16 | PC that the displacement is added to |
| regRdSel | output | 3 | Register read select |
| regRdData | input | 16 | Value of the selected register |
| regWrEn | output | 1 | Register write strobe |
| regWrSel | output | 3 | Register write select |
| regWrData | output | 16 | Updated register value |
| brDone | output | 1 | Result valid, one cycle |
| brTaken | output | 1 | Branch taken |
| nextPc | output | 16 | Branch target, or the presented PC when not taken |
| illegalOp | output | 1 | Control byte bits 7:6 were 11 |

## Verification
Every result is registered once, so a decode or datapath fault shows up in the cycle right after `execValid`. A wrong step kind appears as a `regWrData` off by one or two. A lost byte-width flag appears as a nonzero upper byte, or as a missed zero on a value such as 0x1201 counted down. A swapped branch sense flips `brTaken`, and a bad sign extension moves `nextPc` by 0x0100 or more. The directed cases include wrap at both widths, negative and wrapping targets, and the illegal code, so each of these faults changes at least one sampled port value.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;

  typedef enum logic [1:0] {
    STEP_DEC  = 2'b00,
    STEP_TEST = 2'b01,
    STEP_INC  = 2'b10,
    STEP_BAD  = 2'b11
  } stepKind_e;

  typedef struct packed {
    logic      load;
    logic      legal;
    logic      isByte;
    logic      brOnNz;
    logic      ofsSign;
    stepKind_e step;
  } ctrlStrobe_t;

endpackage

// File: rtl/loopbr_ctrl.sv
module loopbr_ctrl
  import loopbr_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int NUM_REGS = 1 << SEL_W,
  parameter logic [NUM_REGS-1:0] BYTE_REG_MASK = 8'b0000_0111
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        execValid,
  input  logic [7:0]  postByte,
  output ctrlStrobe_t strobe,
  output logic        brDone,
  output logic        illegalOp
);
  localparam int OP_HI  = 7;
  localparam int OP_LO  = 6;
  localparam int NZ_BIT = 5;
  localparam int SG_BIT = 4;

  logic [SEL_W-1:0] regSel;
  stepKind_e        stepKind;

  assign regSel   = postByte[SEL_W-1:0];
  assign stepKind = stepKind_e'(postByte[OP_HI:OP_LO]);

  always_comb begin
    strobe.load    = execValid;
    strobe.step    = stepKind;
    strobe.legal   = (stepKind != STEP_BAD);
    strobe.isByte  = BYTE_REG_MASK[regSel];
    strobe.brOnNz  = postByte[NZ_BIT];
    strobe.ofsSign = postByte[SG_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brDone    <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      brDone    <= execValid;
      illegalOp <= execValid && (stepKind == STEP_BAD);
    end
  end
endmodule

// File: rtl/loopbr_dp.sv
module loopbr_dp
  import loopbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFS_W = 8,
  parameter int SEL_W = 3,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [OFS_W-1:0]  offsetByte,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [SEL_W-1:0]  regWrSel,
  output logic [DATA_W-1:0] regWrData,
  output logic              brTaken,
  output logic [DATA_W-1:0] nextPc
);
  localparam int EXT_W = DATA_W - OFS_W - 1;
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] delta;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] updated;
  logic [DATA_W-1:0] disp;
  logic              isZero;
  logic              takeNow;

  always_comb begin
    unique case (strobe.step)
      STEP_DEC: delta = {DATA_W{1'b1}};
      STEP_INC: delta = DATA_W'(1);
      default:  delta = '0;
    endcase
    sum     = regRdData + delta;
    updated = strobe.isByte ? (sum & NARROW_MASK) : sum;
    isZero  = (updated == '0);
    takeNow = strobe.legal && (strobe.brOnNz ? !isZero : isZero);
    disp    = {{EXT_W{strobe.ofsSign}}, strobe.ofsSign, offsetByte};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrSel  <= '0;
      regWrData <= '0;
      brTaken   <= 1'b0;
      nextPc    <= '0;
    end else begin
      regWrEn <= strobe.load && strobe.legal;
      brTaken <= strobe.load && takeNow;
      if (strobe.load) begin
        regWrSel  <= regSel;
        regWrData <= strobe.legal ? updated : '0;
        nextPc    <= takeNow ? (pcIn + disp) : pcIn;
      end
    end
  end
endmodule

// File: rtl/loopbr_unit.sv
module loopbr_unit
  import loopbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFS_W = 8,
  parameter int SEL_W = 3,
  parameter int NARROW_W = 8,
  parameter logic [(1<<SEL_W)-1:0] BYTE_REG_MASK = 8'b0000_0111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execValid,
  input  logic [7:0]        postByte,
  input  logic [OFS_W-1:0]  offsetByte,
  input  logic [DATA_W-1:0] pcIn,
  output logic [SEL_W-1:0]  regRdSel,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [SEL_W-1:0]  regWrSel,
  output logic [DATA_W-1:0] regWrData,
  output logic              brDone,
  output logic              brTaken,
  output logic [DATA_W-1:0] nextPc,
  output logic              illegalOp
);
  ctrlStrobe_t strobe;

  assign regRdSel = postByte[SEL_W-1:0];

  loopbr_ctrl #(
    .SEL_W(SEL_W),
    .BYTE_REG_MASK(BYTE_REG_MASK)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .execValid(execValid), .postByte(postByte),
    .strobe(strobe), .brDone(brDone), .illegalOp(illegalOp)
  );

  loopbr_dp #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .SEL_W(SEL_W), .NARROW_W(NARROW_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regRdSel),
    .offsetByte(offsetByte), .pcIn(pcIn), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .brTaken(brTaken), .nextPc(nextPc)
  );
endmodule

// File: rtl/loopbr_chk.sv
module loopbr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        execValid,
  input logic [7:0]  postByte,
  input logic [15:0] pcIn,
  input logic        regWrEn,
  input logic [2:0]  regWrSel,
  input logic [15:0] regWrData,
  input logic        brDone,
  input logic        brTaken,
  input logic [15:0] nextPc,
  input logic        illegalOp
);
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    execValid |=> brDone); // R2
  AST_DONE_ONLY_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    !execValid |=> !brDone); // R2
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (brDone && !regWrEn && !brTaken)); // R6
  AST_LEGAL_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (brDone && !illegalOp) |-> regWrEn); // R10
  AST_WR_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    execValid |=> (regWrSel == $past(postByte[2:0]))); // R10
  AST_NOT_TAKEN_PC: assert property (@(posedge clk) disable iff (!rstN)
    execValid && $past(rstN) |=> (brTaken || nextPc == $past(pcIn))); // R8
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrSel < 3'd3) |-> (regWrData[15:8] == 8'h00)); // R9
  AST_SENSE: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && postByte[7:6] != 2'b11) |=>
      (brTaken == ($past(postByte[5]) ? (regWrData != 16'h0) : (regWrData == 16'h0)))); // R7
endmodule

bind loopbr_unit loopbr_chk chk_i (
  .clk(clk), .rstN(rstN), .execValid(execValid), .postByte(postByte),
  .pcIn(pcIn), .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
  .brDone(brDone), .brTaken(brTaken), .nextPc(nextPc), .illegalOp(illegalOp)
);

// File: tb/loopbr_unit_tb_top.sv
`timescale 1ns/1ps
module loopbr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execValid = 1'b0;
  logic [7:0]  postByte = 8'h00;
  logic [7:0]  offsetByte = 8'h00;
  logic [15:0] pcIn = 16'h0000;
  logic [15:0] regRdData = 16'h0000;
  logic [2:0]  regRdSel;
  logic        regWrEn;
  logic [2:0]  regWrSel;
  logic [15:0] regWrData;
  logic        brDone;
  logic        brTaken;
  logic [15:0] nextPc;
  logic        illegalOp;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  loopbr_unit dut_i (
    .clk(clk), .rstN(rstN), .execValid(execValid), .postByte(postByte),
    .offsetByte(offsetByte), .pcIn(pcIn), .regRdSel(regRdSel),
    .regRdData(regRdData), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .brDone(brDone), .brTaken(brTaken),
    .nextPc(nextPc), .illegalOp(illegalOp)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic runCase(string tag, logic [7:0] pb, logic [7:0] ofs,
                         logic [15:0] pc, logic [15:0] rd);
    logic        bad;
    logic        narrow;
    logic [15:0] val;
    logic        take;
    logic [15:0] disp;
    logic [15:0] npc;
    bad    = (pb[7:6] == 2'b11);
    narrow = (pb[2:0] < 3'd3);
    val    = rd;
    if (pb[7:6] == 2'b00) val = val - 16'd1;
    if (pb[7:6] == 2'b10) val = val + 16'd1;
    if (narrow) val = {8'h00, val[7:0]};
    take = !bad && (pb[5] ? (val != 16'h0) : (val == 16'h0));
    disp = pb[4] ? {8'hFF, ofs} : {8'h00, ofs};
    npc  = take ? pc + disp : pc;

    @(negedge clk);
    execValid = 1'b1; postByte = pb; offsetByte = ofs; pcIn = pc; regRdData = rd;
    #1;
    check(tag, "regRdSel (R10)", 16'(regRdSel), 16'(pb[2:0]));
    @(negedge clk);
    execValid = 1'b0;
    check(tag, "brDone (R2)", 16'(brDone), 16'h1);
    check(tag, "illegalOp (R6)", 16'(illegalOp), 16'(bad));
    check(tag, "regWrEn (R10)", 16'(regWrEn), 16'(!bad));
    check(tag, "brTaken (R7)", 16'(brTaken), 16'(take));
    check(tag, "nextPc (R8)", nextPc, npc);
    if (!bad) begin
      check(tag, "regWrSel (R10)", 16'(regWrSel), 16'(pb[2:0]));
      check(tag, "regWrData", regWrData, val);
    end
    @(negedge clk);
    check(tag, "brDone drop (R2)", 16'(brDone), 16'h0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "brDone", 16'(brDone), 16'h0);
    check("R1", "regWrEn", 16'(regWrEn), 16'h0);
    check("R1", "brTaken", 16'(brTaken), 16'h0);
    check("R1", "illegalOp", 16'(illegalOp), 16'h0);
    check("R1", "regWrData", regWrData, 16'h0);
    check("R1", "nextPc", nextPc, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "brDone after release", 16'(brDone), 16'h0);
  endtask

  task automatic testDecrement();
    runCase("R3", 8'h05, 8'h10, 16'h1000, 16'h0001); // X to zero, branch on zero
    runCase("R3", 8'h34, 8'hF0, 16'h2000, 16'h0005); // D, nonzero sense, negative offset
    runCase("R3", 8'h07, 8'h00, 16'h0100, 16'h0000); // SP wraps to 0xFFFF
  endtask

  task automatic testTestOnly();
    runCase("R4", 8'h46, 8'h08, 16'h3000, 16'h0000);
    runCase("R4", 8'h67, 8'h08, 16'h3000, 16'h0000);
  endtask

  task automatic testIncrement();
    runCase("R5", 8'h83, 8'h04, 16'h4000, 16'hFFFF);
    runCase("R11", 8'h84, 8'h04, 16'h4000, 16'h7FFF);
    runCase("R11", 8'hA5, 8'h02, 16'h4000, 16'hFFFF);
  endtask

  task automatic testByteRegs();
    runCase("R9", 8'h00, 8'h20, 16'h5000, 16'h1201);
    runCase("R9", 8'h81, 8'h20, 16'h5000, 16'h00FF);
    runCase("R9", 8'h22, 8'h20, 16'h5000, 16'hAB00);
    runCase("R9", 8'h42, 8'h20, 16'h5000, 16'hFF00);
  endtask

  task automatic testIllegal();
    runCase("R6", 8'hC5, 8'h10, 16'h6000, 16'h0001);
    runCase("R6", 8'hE0, 8'h10, 16'h6000, 16'h0005);
  endtask

  task automatic testBranchSense();
    runCase("R7", 8'h05, 8'h10, 16'h7000, 16'h0005);
    runCase("R7", 8'h25, 8'h10, 16'h7000, 16'h0001);
  endtask

  task automatic testTargets();
    runCase("R8", 8'h45, 8'h20, 16'hFFF0, 16'h0000);
    runCase("R8", 8'h55, 8'h00, 16'h0080, 16'h0000);
    runCase("R8", 8'h55, 8'hFF, 16'h1234, 16'h0000);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    execValid = 1'b1; postByte = 8'h85; offsetByte = 8'h01; pcIn = 16'h0010; regRdData = 16'h0001;
    @(negedge clk);
    postByte = 8'h05; regRdData = 16'h0001;
    check("R2", "first done", 16'(brDone), 16'h1);
    check("R5", "first data", regWrData, 16'h0002);
    @(negedge clk);
    execValid = 1'b0;
    check("R2", "second done", 16'(brDone), 16'h1);
    check("R3", "second data", regWrData, 16'h0000);
    check("R7", "second taken", 16'(brTaken), 16'h1);
    @(negedge clk);
    check("R2", "done idle", 16'(brDone), 16'h0);
  endtask

  initial begin
    testReset();
    testDecrement();
    testTestOnly();
    testIncrement();
    testByteRegs();
    testIllegal();
    testBranchSense();
    testTargets();
    testBackToBack();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule